// File: doc/BRIEF.md
# Register Write-Protection Gate

This block sits on a simple memory-mapped write bus in front of three groups of critical configuration registers. It holds a small lock register. Each of the three low bits of that register unlocks one group. Every bus write is classified by its address. A write to an unlocked group asserts that group's gated write enable in the same cycle. A write to a locked group is dropped, and a one-cycle violation pulse follows it. Writes to any other address raise a pass-through enable and are never blocked.

Groups 0 and 1 unlock with sticky bits, which only an explicit write to the lock register changes. Group 2 unlocks with a one-shot key. Once set, that bit is cleared by the next bus write to any address. The only exception is a further write to the lock register that sets the key again. The write that consumes the key still goes through, so software can set the key and then update exactly one register of group 2.

The group addresses, the lock register address and the bus widths are parameters. Read data shows the lock register whenever the address selects it, and is zero otherwise.

Top module: `wp_guard`

## Requirements
- R1: After reset the four stored lock bits are 0, so all three groups are locked; an idle read at the lock address returns 0x00.
- R2: A write to an address of group g (g = 0, 1, 2) whose unlock bit is 1 asserts bit g of `grp_we` in the same cycle and no other bit of `grp_we`. It does not assert `pass_we`.
- R3: A write to the lock address (default 0x0A) stores write-data bits 3..0. Bit 0 unlocks group 0, bit 1 unlocks group 1 and bit 2 unlocks group 2 (1 = unlocked). The new value governs writes from the next cycle on.
- R4: Lock bit 2 is cleared by any bus write that is not a lock-register write setting bit 2. The write that sets it does not consume it, and a later lock write with bit 2 = 1 leaves it at 1.
- R5: Lock bits 0 and 1 keep their value across writes to every address other than the lock register.
- R6: Read data at the lock address is {zeros, bit3, bit2, bit1, bit0}. Bits 7..4 always read 0 and write data in bits 7..4 is ignored. Bit 3 is stored and read back but unlocks nothing.
- R7: A write to a locked group asserts no bit of `grp_we`, and `viol` is 1 in the following cycle for exactly one cycle per dropped write.
- R8: The write to group 2 that consumes the key asserts `grp_we[2]` in its own cycle. A second group-2 write after it is dropped.
- R9: A write to an address outside the three groups and the lock register asserts `pass_we` in the same cycle and never causes `viol`.
- R10: A write to the lock register asserts neither `pass_we`, any `grp_we` bit, nor `viol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Bus address |
| bus_wdata | input | DW | Bus write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | DW | Lock register value when addressed, else 0 |
| grp_we | output | 3 | Gated write enable per protected group |
| pass_we | output | 1 | Write enable for unprotected addresses |
| viol | output | 1 | Pulse, one cycle after a dropped write |

## Verification
Two functions meet in the same cycle: key consumption and the group-2 write that is allowed to complete. A second pair also meets: key consumption by a write to a locked group, which must clear the key and also raise a violation. The bench sets the key and then issues a group-2 write on the very next cycle. It expects `grp_we[2]` high in that cycle, the key read back as 0 afterwards, and a repeated group-2 write dropped with `viol`. It also sets the key and then writes to locked group 0. In that case it expects no enable, a violation pulse, and the key gone on readback.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;
   localparam int NUM_GRP   = 3;   // protected register groups
   localparam int LOCK_BITS = 4;   // stored lock bits (3..0)
   localparam int SHOT_BIT  = 2;   // one-shot key bit position
   typedef logic [NUM_GRP-1:0]   grp_vec_t;
   typedef logic [LOCK_BITS-1:0] lock_t;
endpackage

// File: rtl/wp_addr_match.sv
module wp_addr_match #(
   parameter int               AW    = 8,
   parameter int               N     = 1,
   parameter logic [N*AW-1:0]  ADDRS = '0
) (
   input  logic [AW-1:0] addr,
   output logic          hit
);
   if (N < 1) begin : g_bad_n
      $error("wp_addr_match: N must be at least 1");
   end

   logic [N-1:0] eq;
   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign eq[i] = (addr == ADDRS[i*AW +: AW]);
   end
   assign hit = |eq;
endmodule

// File: rtl/wp_lock_reg.sv
module wp_lock_reg
   import wp_guard_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  we,
   input  logic  lock_hit,
   input  lock_t wdata,
   output lock_t bits
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bits <= '0;
      end else if (we) begin
         if (lock_hit) bits <= wdata;
         else          bits[SHOT_BIT] <= 1'b0;
      end
   end

   // R4: any other write consumes the key
   a_r4_shot_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !lock_hit && bits[SHOT_BIT]) |=> !bits[SHOT_BIT]);
   // R4: a lock write with bit 2 set leaves the key armed
   a_r4_shot_rearm: assert property (@(posedge clk) disable iff (!rst_n)
      (we && lock_hit && wdata[SHOT_BIT]) |=> bits[SHOT_BIT]);
   // R5: sticky bits untouched by foreign writes
   a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !lock_hit) |=> $stable(bits[1:0]));
   // R1: without a write nothing changes
   a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(bits));
endmodule

// File: rtl/wp_write_gate.sv
module wp_write_gate
   import wp_guard_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     we,
   input  logic     lock_hit,
   input  grp_vec_t grp_hit,
   input  grp_vec_t grp_en,
   output grp_vec_t grp_we,
   output logic     pass_we,
   output logic     viol
);
   logic blocked;

   assign grp_we  = {NUM_GRP{we}} & grp_hit & grp_en;
   assign pass_we = we & ~lock_hit & ~(|grp_hit);
   assign blocked = we & (|(grp_hit & ~grp_en));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) viol <= 1'b0;
      else        viol <= blocked;
   end

   // R7: a dropped write is followed by a violation pulse
   a_r7_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (we && |(grp_hit & ~grp_en)) |=> viol);
   // R9: unprotected writes never raise a violation
   a_r9_no_viol: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !lock_hit && grp_hit == '0) |=> !viol);
   // R2/R9: at most one enable per cycle
   a_r2_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pass_we, grp_we}));
   // R10: lock writes raise no downstream enable
   a_r10_lock_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (we && lock_hit) |-> (!pass_we && grp_we == '0));
endmodule

// File: rtl/wp_guard.sv
module wp_guard
   import wp_guard_pkg::*;
#(
   parameter int                 AW       = 8,
   parameter int                 DW       = 8,
   parameter logic [AW-1:0]      LOCK_ADR = 8'h0A,
   parameter int                 G0_N     = 6,
   parameter int                 G1_N     = 5,
   parameter int                 G2_N     = 2,
   parameter logic [G0_N*AW-1:0] G0_ADRS  = {8'h1D, 8'h1C, 8'h10, 8'h0C, 8'h07, 8'h06},
   parameter logic [G1_N*AW-1:0] G1_ADRS  = {8'h2E, 8'h13, 8'h12, 8'h05, 8'h04},
   parameter logic [G2_N*AW-1:0] G2_ADRS  = {8'h3D, 8'h3C}
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   input  logic          bus_we,
   output logic [DW-1:0] bus_rdata,
   output logic [2:0]    grp_we,
   output logic          pass_we,
   output logic          viol
);
   localparam int PAD_W = DW - LOCK_BITS;

   if (DW <= LOCK_BITS) begin : g_bad_dw
      $error("wp_guard: DW must exceed the lock register width");
   end
   if (AW < 2) begin : g_bad_aw
      $error("wp_guard: AW too small");
   end

   grp_vec_t grp_hit;
   logic     lock_hit;
   lock_t    lock_bits;
   logic     unused_hi;

   assign unused_hi = ^bus_wdata[DW-1:LOCK_BITS];

   wp_addr_match #(.AW(AW), .N(1), .ADDRS(LOCK_ADR)) u_lock_match (
      .addr(bus_addr), .hit(lock_hit));

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      if (g == 0) begin : g_m
         wp_addr_match #(.AW(AW), .N(G0_N), .ADDRS(G0_ADRS)) u_m (
            .addr(bus_addr), .hit(grp_hit[g]));
      end else if (g == 1) begin : g_m
         wp_addr_match #(.AW(AW), .N(G1_N), .ADDRS(G1_ADRS)) u_m (
            .addr(bus_addr), .hit(grp_hit[g]));
      end else begin : g_m
         wp_addr_match #(.AW(AW), .N(G2_N), .ADDRS(G2_ADRS)) u_m (
            .addr(bus_addr), .hit(grp_hit[g]));
      end
   end

   wp_lock_reg u_lock (
      .clk(clk), .rst_n(rst_n), .we(bus_we), .lock_hit(lock_hit),
      .wdata(bus_wdata[LOCK_BITS-1:0]), .bits(lock_bits));

   wp_write_gate u_gate (
      .clk(clk), .rst_n(rst_n), .we(bus_we), .lock_hit(lock_hit),
      .grp_hit(grp_hit), .grp_en(lock_bits[NUM_GRP-1:0]),
      .grp_we(grp_we), .pass_we(pass_we), .viol(viol));

   assign bus_rdata = lock_hit ? {{PAD_W{1'b0}}, lock_bits} : '0;

   // R2: an address belongs to at most one region
   a_r2_decode_unique: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({lock_hit, grp_hit}));
   // R6: unassigned read bits are zero
   a_r6_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[DW-1:LOCK_BITS] == '0);
endmodule

// File: tb/wp_guard_bench.sv
`timescale 1ns/1ps
module wp_guard_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_rdata;
   logic [2:0] grp_we;
   logic       pass_we;
   logic       viol;

   always #2.5 clk = ~clk;

   wp_guard u_wp_guard (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_rdata(bus_rdata), .grp_we(grp_we),
      .pass_we(pass_we), .viol(viol));

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // scoreboard queues (expected per cycle)
   logic [2:0] q_grp[$];
   logic       q_pass[$];
   logic       q_viol[$];
   logic [7:0] q_rd[$];
   string      q_req[$];

   // bench model of the lock bits, from the requirements
   logic [3:0] m_lock = 4'h0;
   logic       m_viol = 1'b0;

   function automatic int region(input logic [7:0] a);
      case (a)
         8'h06, 8'h07, 8'h0C, 8'h10, 8'h1C, 8'h1D: return 0;
         8'h04, 8'h05, 8'h12, 8'h13, 8'h2E:        return 1;
         8'h3C, 8'h3D:                             return 2;
         8'h0A:                                    return 3;
         default:                                  return 4;
      endcase
   endfunction

   task automatic check(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // driver: one bus cycle, pushing the expected outputs
   task automatic cyc(input logic we, input logic [7:0] a, input logic [7:0] d,
                      input string req);
      int r;
      logic [2:0] eg;
      @(negedge clk);
      bus_we = we; bus_addr = a; bus_wdata = d;
      r  = region(a);
      eg = '0;
      if (we && r < 3 && m_lock[r]) eg[r] = 1'b1;
      q_grp.push_back(eg);
      q_pass.push_back(we && r == 4);
      q_viol.push_back(m_viol);
      q_rd.push_back(r == 3 ? {4'h0, m_lock} : 8'h00);
      q_req.push_back(req);
      m_viol = we && r < 3 && !m_lock[r];
      if (we) begin
         if (r == 3) m_lock = d[3:0];
         else        m_lock[2] = 1'b0;
      end
   endtask

   // monitor: sample half a cycle after inputs settle, before the edge
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (q_req.size() > 0) begin
            string rq;
            rq = q_req.pop_front();
            check(rq, "grp_we", {5'h0, grp_we}, {5'h0, q_grp.pop_front()});
            check(rq, "pass_we", {7'h0, pass_we}, {7'h0, q_pass.pop_front()});
            check("R7", "viol", {7'h0, viol}, {7'h0, q_viol.pop_front()});
            check(rq, "rdata", bus_rdata, q_rd.pop_front());
         end
      end
   end

   initial begin
      #1;
      // R1: reset state visible on outputs
      check("R1", "viol in reset", {7'h0, viol}, 8'h00);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cyc(0, 8'h0A, 8'h00, "R1");            // R1 readback 0
      cyc(1, 8'h06, 8'h55, "R1");            // R1/R7 group0 locked
      cyc(1, 8'h2E, 8'h55, "R7");            // R7 group1 locked, back-to-back
      cyc(1, 8'h3D, 8'h55, "R7");            // R7 group2 locked
      cyc(1, 8'h20, 8'h11, "R9");            // R9 pass-through
      cyc(1, 8'h0A, 8'h03, "R10");           // R10 unlock 0 and 1
      cyc(1, 8'h1D, 8'h01, "R2");            // R2 group0
      cyc(1, 8'h12, 8'h01, "R3");            // R3 group1
      cyc(1, 8'h3C, 8'h01, "R3");            // R3 group2 still locked
      cyc(1, 8'h0A, 8'hFF, "R6");            // R6 high bits ignored
      cyc(0, 8'h0A, 8'h00, "R6");            // R6 reads 0x0F
      cyc(1, 8'hF0, 8'h00, "R4");            // R4 pass write consumes key
      cyc(0, 8'h0A, 8'h00, "R5");            // R5 reads 0x0B
      cyc(1, 8'h0C, 8'h00, "R5");            // R5 group0 still open
      cyc(1, 8'h0A, 8'h04, "R3");            // R3 lock 0,1 ; arm key
      cyc(1, 8'h3C, 8'hAA, "R8");            // R8 consuming write completes
      cyc(1, 8'h3D, 8'hAA, "R8");            // R8 second write dropped
      cyc(0, 8'h0A, 8'h00, "R4");            // R4 key gone
      cyc(1, 8'h0A, 8'h04, "R4");            // R4 arm
      cyc(1, 8'h0A, 8'h04, "R4");            // R4 re-arm keeps it
      cyc(0, 8'h0A, 8'h00, "R4");            // reads 0x04
      cyc(1, 8'h06, 8'h00, "R7");            // R7 locked write consumes key
      cyc(0, 8'h0A, 8'h00, "R4");            // reads 0x00
      cyc(1, 8'h3D, 8'h00, "R7");            // R7 dropped
      cyc(1, 8'h0A, 8'h08, "R6");            // R6 bit3 stored, unlocks nothing
      cyc(1, 8'h07, 8'h00, "R6");
      cyc(0, 8'h0A, 8'h00, "R6");            // reads 0x08
      cyc(1, 8'h0A, 8'h00, "R10");           // R10 lock write quiet
      cyc(0, 8'h00, 8'h00, "R9");
      cyc(0, 8'h00, 8'h00, "R9");
      repeat (3) @(negedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule